// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This unit sits beside a small set-associative cache and follows a single hardware transaction. Each cache line carries a speculative read mark, a speculative write mark, a per-word mask of speculatively stored words and a per-word mask of committed words. Loads and stores from the local core set the marks. Stores land in a speculative copy of the line that no other agent can see. A commit publishes every speculative word of every line on one clock edge. An abort throws away every speculative word and clears every mark on one clock edge.

Coherence snoops from other agents are checked against the marks as they arrive. A conflict aborts the transaction on the next edge and does not wait for commit. An external eviction notice for a write-marked line also aborts. So does a local request that needs a new line in a set where every way already holds speculative writes. A 2-bit cause code tells the three reasons apart. Other agents read committed data through a combinational peer port.

The local request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low when no transaction is running, in a cycle where `tx_commit` or `tx_abort` is driven, and while a load response is stalled. A load response is presented on `rsp_valid`/`rsp_data` and is held until `rsp_ready` is high. Stores produce no response.

Top module: `txn_conflict_tracker`

## Requirements
- R1: With no transaction running, `tx_begin` sets `tx_active` on the next edge and clears `abort_flag`. After an abort, `abort_flag` and `abort_code` keep their values until the next accepted `tx_begin`.
- R2: Words stored inside a transaction are not visible on the peer port (`peer_hit` low) before commit. On the edge that takes `tx_commit`, they become visible, `commit_evt` pulses for one cycle and `tx_active` drops.
- R3: A read snoop (`snp_write`=0) that hits a line carrying only the read mark does not abort.
- R4: A write snoop that hits a line with the read or the write mark aborts on the next edge. `tx_active` falls, `abort_evt` pulses, `abort_flag` rises and `abort_code` becomes 0 (conflict).
- R5: A read snoop that hits a write-marked line aborts with `abort_code` 0.
- R6: During a transaction, an eviction notice for a write-marked line aborts with `abort_code` 1 (capacity/eviction). An eviction notice for a line without the write mark does not abort, and the line is dropped.
- R7: A request that misses in a set where every way carries the write mark aborts with `abort_code` 1 and does not evict any line.
- R8: `tx_abort` aborts with `abort_code` 2. Speculative words are discarded, and words committed earlier stay visible on the peer port.
- R9: If `tx_commit` arrives in the same cycle as an abort condition, the abort wins. `commit_evt` stays low and nothing is published.
- R10: With no transaction running, `req_ready` is low, and snoops and eviction notices never raise an abort.
- R11: A load returns the transaction's own stored word if one exists, otherwise the committed word, otherwise zero. Address layout: bits [5:0] give the byte within the 64-byte line, bits [5:2] give the 32-bit word, the next log2(sets) bits give the set, and the remaining upper bits are the tag.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value and `req_ready` is low.
- R13: When several abort causes meet in one cycle, conflict (0) beats capacity (1), and capacity beats explicit (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Start a transaction |
| tx_commit | input | 1 | Commit the running transaction |
| tx_abort | input | 1 | Explicit abort request |
| req_valid | input | 1 | Local request valid |
| req_ready | output | 1 | Local request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Physical byte address of the request |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load response valid |
| rsp_ready | input | 1 | Load response taken |
| rsp_data | output | 32 | Load data |
| snp_valid | input | 1 | Snoop valid |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | 32 | Snoop address |
| evict_valid | input | 1 | Eviction notice valid |
| evict_addr | input | 32 | Address of the line being evicted |
| peer_addr | input | 32 | Address read by other agents |
| peer_hit | output | 1 | Committed word present at peer_addr |
| peer_data | output | 32 | Committed word at peer_addr, zero when absent |
| tx_active | output | 1 | Transaction running |
| commit_evt | output | 1 | One-cycle pulse after a commit |
| abort_evt | output | 1 | One-cycle pulse after an abort |
| abort_flag | output | 1 | Last transaction aborted; held until next begin |
| abort_code | output | 2 | 0 conflict, 1 capacity/eviction, 2 explicit, 3 unused |

## Verification
The bench targets the asymmetric conflict rule. A read snoop on a read-only line must leave the transaction running, while a read snoop on a written line must kill it; a design that checks only the address, or only the snoop type, fails one of the two. It drives a commit in the same cycle as a conflicting snoop, where a wrong priority would publish the stores. It fills a set with written lines to force the capacity abort, which a naive design would settle by evicting a dirty way. It stacks all three causes in one cycle and stalls a load response, which catches a wrong code order, a response that changes or is lost under back-pressure, and committed data wiped by an abort.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    CAUSE_CONFLICT = 2'd0,
    CAUSE_CAPACITY = 2'd1,
    CAUSE_EXPLICIT = 2'd2,
    CAUSE_UNUSED   = 2'd3
  } cause_e;
endpackage

// File: rtl/tct_way_match.sv
// Tag compare across the ways of one set.
module tct_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 24,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_vld[g] && (way_tag[g] == probe_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end

  // A line address is never held twice in a set (R11).
  always_comb
    if (!$isunknown(match))
      assert_unique_line_R11: assert ($onehot0(match))
        else $error("duplicate tag in set");
endmodule

// File: rtl/tct_victim_pick.sv
// Victim choice: free way first, then an unmarked way, then a read-only way.
module tct_victim_pick #(
  parameter int WAYS  = 2,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [WAYS-1:0]  way_rd,
  input  logic [WAYS-1:0]  way_wr,
  output logic             ok,
  output logic [WAY_W-1:0] way
);
  logic             f_free, f_clean, f_rdonly;
  logic [WAY_W-1:0] w_free, w_clean, w_rdonly;

  always_comb begin
    f_free = 1'b0; f_clean = 1'b0; f_rdonly = 1'b0;
    w_free = '0;   w_clean = '0;   w_rdonly = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin f_free = 1'b1; w_free = WAY_W'(w); end
      if (!way_rd[w] && !way_wr[w]) begin f_clean = 1'b1; w_clean = WAY_W'(w); end
      if (!way_wr[w]) begin f_rdonly = 1'b1; w_rdonly = WAY_W'(w); end
    end
    ok  = f_free | f_clean | f_rdonly;
    way = f_free ? w_free : (f_clean ? w_clean : w_rdonly);
  end
endmodule

// File: rtl/tct_txn_ctrl.sv
// Transaction state, outcome arbitration and cause encoding.
module tct_txn_ctrl
  import tct_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_begin,
  input  logic   tx_commit,
  input  logic   tx_abort,
  input  logic   hit_conflict,
  input  logic   hit_capacity,
  output logic   active,
  output logic   do_abort,
  output logic   do_commit,
  output logic   commit_evt,
  output logic   abort_evt,
  output logic   abort_flag,
  output cause_e abort_code
);
  cause_e next_cause;

  always_comb begin
    do_abort  = active && (hit_conflict || hit_capacity || tx_abort);
    do_commit = active && tx_commit && !do_abort;
    if (hit_conflict)      next_cause = CAUSE_CONFLICT;
    else if (hit_capacity) next_cause = CAUSE_CAPACITY;
    else                   next_cause = CAUSE_EXPLICIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      commit_evt <= 1'b0;
      abort_evt  <= 1'b0;
      abort_flag <= 1'b0;
      abort_code <= CAUSE_CONFLICT;
    end else begin
      commit_evt <= do_commit;
      abort_evt  <= do_abort;
      if (do_abort) begin
        active     <= 1'b0;
        abort_flag <= 1'b1;
        abort_code <= next_cause;
      end else if (do_commit) begin
        active <= 1'b0;
      end else if (!active && tx_begin) begin
        active     <= 1'b1;
        abort_flag <= 1'b0;
      end
    end
  end

  assert_begin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && tx_begin) |=> (active && !abort_flag));

  assert_code_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && abort_flag && !tx_begin) |=> (abort_flag && $stable(abort_code)));

  assert_abort_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_abort |=> (!active && abort_flag && abort_evt));

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_evt && abort_evt));
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import tct_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 4,
  parameter int NUM_WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              tx_abort,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [ADDR_W-1:0] peer_addr,
  output logic              peer_hit,
  output logic [DATA_W-1:0] peer_data,
  output logic              tx_active,
  output logic              commit_evt,
  output logic              abort_evt,
  output logic              abort_flag,
  output logic [1:0]        abort_code
);
  localparam int WORDS  = LINE_BYTES * 8 / DATA_W;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int NPRB   = 4;  // 0 local request, 1 snoop, 2 eviction, 3 peer

  // Line state
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tag_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            vld_q, rd_q, wr_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][WORDS-1:0] spec_msk_q, com_msk_q;
  logic [DATA_W-1:0] spec_dat_q [NUM_SETS][NUM_WAYS][WORDS];
  logic [DATA_W-1:0] com_dat_q  [NUM_SETS][NUM_WAYS][WORDS];

  // Address probes
  logic [NPRB-1:0][ADDR_W-1:0] prb_addr;
  logic [NPRB-1:0][SET_W-1:0]  prb_set;
  logic [NPRB-1:0]             prb_hit;
  logic [NPRB-1:0][WAY_W-1:0]  prb_way;

  assign prb_addr = {peer_addr, evict_addr, snp_addr, req_addr};

  for (genvar p = 0; p < NPRB; p++) begin : g_probe
    assign prb_set[p] = prb_addr[p][OFF_W +: SET_W];
    tct_way_match #(.WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
      .way_tag  (tag_q[prb_set[p]]),
      .way_vld  (vld_q[prb_set[p]]),
      .probe_tag(prb_addr[p][ADDR_W-1 -: TAG_W]),
      .hit      (prb_hit[p]),
      .hit_way  (prb_way[p])
    );
  end

  logic unused_low_bits;
  assign unused_low_bits = ^{prb_addr[0][OFF_W-1:0], prb_addr[1][OFF_W-1:0],
                             prb_addr[2][OFF_W-1:0], prb_addr[3][OFF_W-1:0],
                             req_addr[BYTE_W-1:0], peer_addr[BYTE_W-1:0]};

  // Local request path
  logic [SET_W-1:0]  r_set;
  logic [WORD_W-1:0] r_word;
  logic              vict_ok;
  logic [WAY_W-1:0]  vict_way, r_way;
  logic              req_fire, req_go;
  logic [DATA_W-1:0] load_val;

  assign r_set  = prb_set[0];
  assign r_word = req_addr[BYTE_W +: WORD_W];

  tct_victim_pick #(.WAYS(NUM_WAYS)) u_victim (
    .way_vld(vld_q[r_set]),
    .way_rd (rd_q[r_set]),
    .way_wr (wr_q[r_set]),
    .ok     (vict_ok),
    .way    (vict_way)
  );

  assign r_way = prb_hit[0] ? prb_way[0] : vict_way;

  // Outcome inputs
  logic   conflict, capacity, do_abort, do_commit;
  cause_e code_q;

  assign conflict = snp_valid && prb_hit[1] &&
                    (wr_q[prb_set[1]][prb_way[1]] ||
                     (snp_write && rd_q[prb_set[1]][prb_way[1]]));
  assign capacity = (req_fire && !prb_hit[0] && !vict_ok) ||
                    (evict_valid && prb_hit[2] && wr_q[prb_set[2]][prb_way[2]]);

  tct_txn_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_begin    (tx_begin),
    .tx_commit   (tx_commit),
    .tx_abort    (tx_abort),
    .hit_conflict(conflict),
    .hit_capacity(capacity),
    .active      (tx_active),
    .do_abort    (do_abort),
    .do_commit   (do_commit),
    .commit_evt  (commit_evt),
    .abort_evt   (abort_evt),
    .abort_flag  (abort_flag),
    .abort_code  (code_q)
  );
  assign abort_code = code_q;

  assign req_ready = tx_active && !tx_commit && !tx_abort && !(rsp_valid && !rsp_ready);
  assign req_fire  = req_valid && req_ready;
  assign req_go    = req_fire && (prb_hit[0] || vict_ok) && !do_abort;

  always_comb begin
    load_val = '0;
    if (prb_hit[0]) begin
      if (spec_msk_q[r_set][r_way][r_word])     load_val = spec_dat_q[r_set][r_way][r_word];
      else if (com_msk_q[r_set][r_way][r_word]) load_val = com_dat_q[r_set][r_way][r_word];
    end
  end

  // Load response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Tags, marks and word masks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q      <= '0;
      vld_q      <= '0;
      rd_q       <= '0;
      wr_q       <= '0;
      spec_msk_q <= '0;
      com_msk_q  <= '0;
    end else begin
      if (evict_valid && prb_hit[2]) begin
        vld_q[prb_set[2]][prb_way[2]]      <= 1'b0;
        rd_q[prb_set[2]][prb_way[2]]       <= 1'b0;
        wr_q[prb_set[2]][prb_way[2]]       <= 1'b0;
        spec_msk_q[prb_set[2]][prb_way[2]] <= '0;
        com_msk_q[prb_set[2]][prb_way[2]]  <= '0;
      end
      if (do_abort) begin
        rd_q       <= '0;
        wr_q       <= '0;
        spec_msk_q <= '0;
      end else if (do_commit) begin
        rd_q       <= '0;
        wr_q       <= '0;
        spec_msk_q <= '0;
        for (int s = 0; s < NUM_SETS; s++)
          for (int w = 0; w < NUM_WAYS; w++)
            com_msk_q[s][w] <= com_msk_q[s][w] | spec_msk_q[s][w];
      end else if (req_go) begin
        if (!prb_hit[0]) begin
          vld_q[r_set][r_way]     <= 1'b1;
          tag_q[r_set][r_way]     <= req_addr[ADDR_W-1 -: TAG_W];
          rd_q[r_set][r_way]      <= 1'b0;
          wr_q[r_set][r_way]      <= 1'b0;
          com_msk_q[r_set][r_way] <= '0;
          spec_msk_q[r_set][r_way] <= '0;
        end
        if (req_write) begin
          wr_q[r_set][r_way] <= 1'b1;
          spec_msk_q[r_set][r_way] <=
            (prb_hit[0] ? spec_msk_q[r_set][r_way] : '0) | (WORDS'(1) << r_word);
        end else begin
          rd_q[r_set][r_way] <= 1'b1;
        end
      end
    end
  end

  // Word storage
  always_ff @(posedge clk) begin
    if (req_go && req_write)
      spec_dat_q[r_set][r_way][r_word] <= req_wdata;
    if (do_commit)
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          for (int k = 0; k < WORDS; k++)
            if (spec_msk_q[s][w][k]) com_dat_q[s][w][k] <= spec_dat_q[s][w][k];
  end

  // Peer view: committed words only
  logic [WORD_W-1:0] p_word;
  assign p_word    = peer_addr[BYTE_W +: WORD_W];
  assign peer_hit  = prb_hit[3] && com_msk_q[prb_set[3]][prb_way[3]][p_word];
  assign peer_data = peer_hit ? com_dat_q[prb_set[3]][prb_way[3]][p_word] : '0;

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_idle_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> !abort_evt);

  assert_idle_marks_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (rd_q == '0 && wr_q == '0));
endmodule

// File: tb/tb_txn_conflict_tracker.sv
module tb_txn_conflict_tracker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_begin, tx_commit, tx_abort;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_data;
  logic        snp_valid, snp_write;
  logic [31:0] snp_addr;
  logic        evict_valid;
  logic [31:0] evict_addr, peer_addr;
  logic        peer_hit;
  logic [31:0] peer_data;
  logic        tx_active, commit_evt, abort_evt, abort_flag;
  logic [1:0]  abort_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [31:0] exp_q[$];
  logic [31:0] exp_item;

  localparam logic [31:0] A = 32'h0000_1000;  // set 0
  localparam logic [31:0] B = 32'h0000_2000;  // set 0
  localparam logic [31:0] C = 32'h0000_3000;  // set 0
  localparam logic [31:0] D = 32'h0000_1040;  // set 1

  always #10 clk = ~clk;  // 50 MHz

  txn_conflict_tracker dut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .peer_addr(peer_addr),
    .peer_hit(peer_hit), .peer_data(peer_data), .tx_active(tx_active), .commit_evt(commit_evt),
    .abort_evt(abort_evt), .abort_flag(abort_flag), .abort_code(abort_code)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic begin_tx(); tx_begin = 1; cyc(); tx_begin = 0; endtask
  task automatic commit_tx(); tx_commit = 1; cyc(); tx_commit = 0; endtask
  task automatic abort_tx(); tx_abort = 1; cyc(); tx_abort = 0; endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    cyc();
    req_valid = 0; req_write = 0;
  endtask

  task automatic load(input logic [31:0] a, input logic [31:0] e);
    exp_q.push_back(e);
    req_valid = 1; req_write = 0; req_addr = a;
    cyc();
    req_valid = 0;
  endtask

  task automatic snoop(input logic [31:0] a, input logic w);
    snp_valid = 1; snp_write = w; snp_addr = a;
    cyc();
    snp_valid = 0; snp_write = 0;
  endtask

  task automatic evict(input logic [31:0] a);
    evict_valid = 1; evict_addr = a;
    cyc();
    evict_valid = 0;
  endtask

  task automatic peek(input logic [31:0] a);
    peer_addr = a; #1;
  endtask

  // Scoreboard monitor: compares each handed-off load response (R11)
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", rsp_data, 32'h0);
      else begin
        exp_item = exp_q.pop_front();
        chk(rsp_data == exp_item, "R11 load data", rsp_data, exp_item);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_begin = 0; tx_commit = 0; tx_abort = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; rsp_ready = 1;
    snp_valid = 0; snp_write = 0; snp_addr = 0; evict_valid = 0; evict_addr = 0; peer_addr = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // Reset state
    chk(!tx_active, "R1 reset idle", 32'(tx_active), 0);
    chk(!abort_flag, "R1 reset flag", 32'(abort_flag), 0);
    chk(!req_ready, "R10 idle not ready", 32'(req_ready), 0);

    // Idle: snoops and evictions are harmless
    snoop(A, 1'b1); evict(A); cyc();
    chk(!abort_flag && !tx_active, "R10 idle snoop/evict", 32'(abort_flag), 0);

    // Store, forward, commit, publish
    begin_tx();
    chk(tx_active, "R1 begin", 32'(tx_active), 1);
    store(A, 32'h11); store(A + 4, 32'h22);
    peek(A);
    chk(!peer_hit, "R2 hidden before commit", 32'(peer_hit), 0);
    load(A, 32'h11); load(A + 8, 32'h0);
    commit_tx();
    chk(commit_evt && !tx_active, "R2 commit pulse", 32'(commit_evt), 1);
    peek(A + 4);
    chk(peer_hit && peer_data == 32'h22, "R2 published", peer_data, 32'h22);

    // Read snoop on read-only line, then write snoop
    begin_tx();
    load(A, 32'h11);
    snoop(A, 1'b0);
    chk(tx_active && !abort_flag, "R3 read/read no abort", 32'(abort_flag), 0);
    snoop(A, 1'b1);
    chk(abort_evt && abort_flag && !tx_active, "R4 write snoop aborts", 32'(abort_flag), 1);
    chk(abort_code == 2'd0, "R4 conflict code", 32'(abort_code), 0);
    cyc(); cyc();
    chk(abort_flag && abort_code == 2'd0, "R1 code held", 32'(abort_code), 0);

    // Read snoop on written line
    begin_tx();
    chk(!abort_flag, "R1 flag cleared by begin", 32'(abort_flag), 0);
    store(B, 32'h55);
    snoop(B, 1'b0);
    chk(abort_flag && abort_code == 2'd0, "R5 read hits write set", 32'(abort_code), 0);
    peek(B);
    chk(!peer_hit, "R5 discarded store", 32'(peer_hit), 0);

    // Explicit abort keeps committed data
    begin_tx();
    store(A, 32'h99);
    abort_tx();
    chk(abort_flag && abort_code == 2'd2, "R8 explicit code", 32'(abort_code), 2);
    peek(A);
    chk(peer_hit && peer_data == 32'h11, "R8 committed kept", peer_data, 32'h11);

    // Eviction of written line vs clean line
    begin_tx();
    store(A + 4, 32'h77);
    evict(A);
    chk(abort_flag && abort_code == 2'd1, "R6 evict written line", 32'(abort_code), 1);
    begin_tx();
    load(D, 32'h0);
    evict(D);
    chk(tx_active && !abort_flag, "R6 evict clean line", 32'(abort_flag), 0);
    commit_tx();
    chk(commit_evt, "R2 commit read-only tx", 32'(commit_evt), 1);

    // Capacity: both ways of set 0 written, third line needed
    begin_tx();
    store(A, 32'h1); store(B, 32'h2);
    chk(tx_active, "R7 two ways fit", 32'(tx_active), 1);
    store(C, 32'h3);
    chk(abort_flag && abort_code == 2'd1, "R7 capacity code", 32'(abort_code), 1);

    // Commit meets conflict
    begin_tx();
    store(D, 32'h42);
    tx_commit = 1; snp_valid = 1; snp_write = 1; snp_addr = D;
    cyc();
    tx_commit = 0; snp_valid = 0; snp_write = 0;
    chk(!commit_evt && abort_flag && abort_code == 2'd0, "R9 abort wins", 32'(commit_evt), 0);
    peek(D);
    chk(!peer_hit, "R9 nothing published", 32'(peer_hit), 0);

    // Cause priority
    begin_tx();
    store(A, 32'h7);
    tx_abort = 1; snp_valid = 1; snp_write = 1; snp_addr = A; evict_valid = 1; evict_addr = A;
    cyc();
    tx_abort = 0; snp_valid = 0; snp_write = 0; evict_valid = 0;
    chk(abort_code == 2'd0, "R13 conflict first", 32'(abort_code), 0);
    begin_tx();
    store(A, 32'h8);
    tx_abort = 1; evict_valid = 1; evict_addr = A;
    cyc();
    tx_abort = 0; evict_valid = 0;
    chk(abort_code == 2'd1, "R13 capacity over explicit", 32'(abort_code), 1);

    // Back-pressure on the load response
    begin_tx();
    store(A, 32'h5);
    rsp_ready = 0;
    load(A, 32'h5);
    chk(rsp_valid && !req_ready, "R12 stall blocks requests", 32'(req_ready), 0);
    cyc();
    chk(rsp_valid && rsp_data == 32'h5, "R12 data held", rsp_data, 32'h5);
    rsp_ready = 1;
    cyc();
    commit_tx();
    cyc();
    chk(exp_q.size() == 0, "R11 all responses seen", 32'(exp_q.size()), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule